// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic and logic stage of a small RISC core. Each cycle it takes an operation code, two 8-bit operands (the second may be a register or an immediate the core has already selected), and the current status byte. It produces the 8-bit result, a write-back strobe and the next status byte. The carry consumed by the carry-using operations is the C bit of the incoming status byte.

Every operation class updates only its own subset of status bits and passes the rest through unchanged. Operations that produce no register value, such as compares and flag set or clear, lower the write-back strobe. Outputs are registered, so the result for inputs presented at one rising edge appears after that edge. A synchronous active-high reset clears all outputs.

Top module: `alu8_status`

## Requirements
- R1: Status bit order from 7 down to 0 is I, T, H, S, V, N, Z, C. Outputs are registered with one cycle of latency. While `rst` is high at a rising edge, `result_o`, `status_o` and `wr_o` become 0.
- R2: Op 0 (add) and op 1 (add plus C) give a+b(+C) with `wr_o`=1. C is set on a carry out of bit 7, H on a carry out of bit 3, and V on signed overflow. N and Z follow the result.
- R3: Op 2 (subtract) and op 3 (subtract minus C) give a-b(-C) with `wr_o`=1. C is set on a borrow out of bit 7 and H on a borrow out of bit 3. V is set on signed overflow and N follows the result. For op 3, Z is 1 only if the result is zero and the incoming Z was 1.
- R4: Op 4 (compare) and op 5 (compare minus C) update flags exactly as ops 2 and 3, with `wr_o`=0.
- R5: Ops 6, 7, 8 and 13 (AND, OR, XOR, test, where test returns a) update Z and N from the result and clear V. C and H are unchanged and `wr_o`=1.
- R6: Op 9 returns 0xFF-a and sets C=1 and V=0. Z and N follow the result. H is unchanged.
- R7: Op 10 returns 0x00-a, with C, H, V, N and Z set as for a subtraction of a from zero.
- R8: Op 11 returns a+1 and op 12 returns a-1. V is set only when a was 0x7F for op 11 or 0x80 for op 12. Z and N follow the result. C and H are unchanged.
- R9: Op 14 shifts left with a 0 into bit 0. Op 15 shifts right with a 0 into bit 7. Op 18 shifts right and keeps bit 7. C receives the bit shifted out, V=N xor C, and H is unchanged.
- R10: Op 16 shifts left with C into bit 0 and bit 7 into C. Op 17 shifts right with C into bit 7 and bit 0 into C. V=N xor C and H is unchanged.
- R11: Op 19 exchanges the two nibbles of a, with `wr_o`=1, and leaves the status byte unchanged.
- R12: Op 20 sets and op 21 clears the status bit indexed by `b_i[2:0]`. All other status bits are unchanged, `wr_o`=0 and `result_o`=a.
- R13: Whenever N or V is updated, S equals N xor V. I and T change only through R12.
- R14: Op codes 22 to 31 give `wr_o`=0, `result_o`=a and an unchanged status byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation code |
| a_i | input | 8 | First operand (destination register value) |
| b_i | input | 8 | Second operand, or status bit index for ops 20 and 21 |
| status_i | input | 8 | Current status byte |
| result_o | output | 8 | Registered result |
| status_o | output | 8 | Registered next status byte |
| wr_o | output | 1 | Registered write-back strobe for the result |

## Verification
The carry-chain operations are swept over every value of a. They are paired with sixteen b values chosen at the nibble and sign boundaries (0x0F/0x10, 0x7F/0x80, 0xFF), and with all four combinations of incoming C and Z. This separates carry from half-carry, signed overflow from unsigned carry, and the sticky zero of the carry-using subtract and compare from the plain zero. The unary operations, shifts and rotates see every a under both carry values. This exposes any wrong bit fed into the vacated position. Flag set and clear run over every index against all 256 incoming status bytes, so a stray change to a neighbouring bit shows up. The bits above the updated subset are also varied on every vector, so a leak into I, T or an untouched flag is caught.

// File: rtl/alu8_status_pkg.sv
package alu8_status_pkg;
  localparam int OP_W = 5;
  localparam int SR_W = 8;

  // status bit positions
  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_V = 3;
  localparam int FL_S = 4;
  localparam int FL_H = 5;
  localparam int FL_T = 6;
  localparam int FL_I = 7;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
    OP_CMP  = 5'd4,  OP_CMPC = 5'd5,  OP_AND  = 5'd6,  OP_OR   = 5'd7,
    OP_XOR  = 5'd8,  OP_COM  = 5'd9,  OP_NEG  = 5'd10, OP_INC  = 5'd11,
    OP_DEC  = 5'd12, OP_TST  = 5'd13, OP_LSL  = 5'd14, OP_LSR  = 5'd15,
    OP_ROL  = 5'd16, OP_ROR  = 5'd17, OP_ASR  = 5'd18, OP_SWAP = 5'd19,
    OP_FSET = 5'd20, OP_FCLR = 5'd21
  } alu_op_e;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         sub_i,
  input  logic         cin_i,   // carry for add, borrow for subtract
  output logic [W-1:0] r_o,
  output logic         c_o,     // carry out / borrow out of MSB
  output logic         h_o,     // carry / borrow out of the low half
  output logic         v_o
);
  localparam int HW = W / 2;

  logic [W-1:0]  y_eff;
  logic          ci;
  logic [W:0]    full;
  logic [HW:0]   low;

  always_comb begin
    y_eff = sub_i ? ~y_i : y_i;
    ci    = cin_i ^ sub_i;
    full  = {1'b0, x_i} + {1'b0, y_eff} + {{W{1'b0}}, ci};
    low   = {1'b0, x_i[HW-1:0]} + {1'b0, y_eff[HW-1:0]} + {{HW{1'b0}}, ci};
    r_o   = full[W-1:0];
    c_o   = full[W] ^ sub_i;
    h_o   = low[HW] ^ sub_i;
    v_o   = (x_i[W-1] == y_eff[W-1]) && (full[W-1] != x_i[W-1]);
  end
endmodule

// File: rtl/alu8_shifter.sv
module alu8_shifter
  import alu8_status_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic         cin_i,
  output logic [W-1:0] r_o,
  output logic         cout_o
);
  always_comb begin
    r_o    = a_i;
    cout_o = 1'b0;
    case (op_i)
      OP_LSL: begin r_o = {a_i[W-2:0], 1'b0};      cout_o = a_i[W-1]; end
      OP_ROL: begin r_o = {a_i[W-2:0], cin_i};     cout_o = a_i[W-1]; end
      OP_LSR: begin r_o = {1'b0, a_i[W-1:1]};      cout_o = a_i[0];   end
      OP_ROR: begin r_o = {cin_i, a_i[W-1:1]};     cout_o = a_i[0];   end
      OP_ASR: begin r_o = {a_i[W-1], a_i[W-1:1]};  cout_o = a_i[0];   end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu8_status.sv
module alu8_status
  import alu8_status_pkg::*;
#(
  parameter int W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [SR_W-1:0] status_i,
  output logic [W-1:0]    result_o,
  output logic [SR_W-1:0] status_o,
  output logic            wr_o
);
  localparam int HW = W / 2;
  localparam int IDX_W = $clog2(SR_W);

  alu_op_e op;
  assign op = alu_op_e'(op_i);

  // shared adder/subtractor operand selection
  logic [W-1:0] as_x, as_y, as_r;
  logic         as_sub, as_cin, as_c, as_h, as_v;

  always_comb begin
    as_x   = a_i;
    as_y   = b_i;
    as_sub = 1'b0;
    as_cin = 1'b0;
    case (op)
      OP_ADC:           as_cin = status_i[FL_C];
      OP_SUB, OP_CMP:   as_sub = 1'b1;
      OP_SBC, OP_CMPC:  begin as_sub = 1'b1; as_cin = status_i[FL_C]; end
      OP_NEG:           begin as_x = '0; as_y = a_i; as_sub = 1'b1; end
      OP_INC:           as_y = W'(1);
      OP_DEC:           begin as_y = W'(1); as_sub = 1'b1; end
      default: ;
    endcase
  end

  alu8_addsub #(.W(W)) u_addsub (
    .x_i(as_x), .y_i(as_y), .sub_i(as_sub), .cin_i(as_cin),
    .r_o(as_r), .c_o(as_c), .h_o(as_h), .v_o(as_v)
  );

  logic [W-1:0] sh_r;
  logic         sh_c;

  alu8_shifter #(.W(W)) u_shifter (
    .op_i(op), .a_i(a_i), .cin_i(status_i[FL_C]), .r_o(sh_r), .cout_o(sh_c)
  );

  // result and flag merge
  logic [W-1:0]    res_d;
  logic [SR_W-1:0] st_d;
  logic            wr_d, upd_zn, sticky_z;

  always_comb begin
    res_d    = a_i;
    st_d     = status_i;
    wr_d     = 1'b0;
    upd_zn   = 1'b0;
    sticky_z = 1'b0;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG, OP_CMP, OP_CMPC: begin
        res_d      = as_r;
        wr_d       = (op != OP_CMP) && (op != OP_CMPC);
        st_d[FL_H] = as_h;
        st_d[FL_C] = as_c;
        st_d[FL_V] = as_v;
        upd_zn     = 1'b1;
        sticky_z   = (op == OP_SBC) || (op == OP_CMPC);
      end
      OP_AND, OP_OR, OP_XOR, OP_TST: begin
        case (op)
          OP_AND:  res_d = a_i & b_i;
          OP_OR:   res_d = a_i | b_i;
          OP_XOR:  res_d = a_i ^ b_i;
          default: res_d = a_i;
        endcase
        wr_d       = 1'b1;
        st_d[FL_V] = 1'b0;
        upd_zn     = 1'b1;
      end
      OP_COM: begin
        res_d      = ~a_i;
        wr_d       = 1'b1;
        st_d[FL_C] = 1'b1;
        st_d[FL_V] = 1'b0;
        upd_zn     = 1'b1;
      end
      OP_INC, OP_DEC: begin
        res_d      = as_r;
        wr_d       = 1'b1;
        st_d[FL_V] = as_v;
        upd_zn     = 1'b1;
      end
      OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
        res_d      = sh_r;
        wr_d       = 1'b1;
        st_d[FL_C] = sh_c;
        st_d[FL_V] = sh_r[W-1] ^ sh_c;
        upd_zn     = 1'b1;
      end
      OP_SWAP: begin
        res_d = {a_i[HW-1:0], a_i[W-1:HW]};
        wr_d  = 1'b1;
      end
      OP_FSET: st_d[b_i[IDX_W-1:0]] = 1'b1;
      OP_FCLR: st_d[b_i[IDX_W-1:0]] = 1'b0;
      default: ;
    endcase
    if (upd_zn) begin
      st_d[FL_N] = res_d[W-1];
      st_d[FL_Z] = (res_d == '0) && (!sticky_z || status_i[FL_Z]);
      st_d[FL_S] = st_d[FL_N] ^ st_d[FL_V];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      status_o <= '0;
      wr_o     <= 1'b0;
    end else begin
      result_o <= res_d;
      status_o <= st_d;
      wr_o     <= wr_d;
    end
  end
endmodule

// File: rtl/alu8_status_chk.sv
module alu8_status_chk
  import alu8_status_pkg::*;
#(
  parameter int W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [OP_W-1:0] op_i,
  input logic [W-1:0]    a_i,
  input logic [W-1:0]    b_i,
  input logic [SR_W-1:0] status_i,
  input logic [W-1:0]    result_o,
  input logic [SR_W-1:0] status_o,
  input logic            wr_o
);
  localparam int HW = W / 2;

  // R1: reset clears every output on the following edge
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (result_o == '0 && status_o == '0 && !wr_o));

  // R4: compares never request a write-back
  a_r4_cmp_no_write: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_i) == OP_CMP || $past(op_i) == OP_CMPC)) |-> !wr_o);

  // R5: logic ops clear V and keep C and H
  a_r5_logic_flags: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_i) == OP_AND || $past(op_i) == OP_OR || $past(op_i) == OP_XOR))
    |-> (!status_o[FL_V] && status_o[FL_C] == $past(status_i[FL_C])
         && status_o[FL_H] == $past(status_i[FL_H])));

  // R11: nibble swap with status passed through
  a_r11_swap: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == OP_SWAP)
    |-> (status_o == $past(status_i) && wr_o
         && result_o == {$past(a_i[HW-1:0]), $past(a_i[W-1:HW])}));

  // R12: flag set lands on the indexed bit
  a_r12_flag_set: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == OP_FSET) |-> (status_o[$past(b_i[2:0])] && !wr_o));

  // R13: I and T untouched outside flag set/clear
  a_r13_it_kept: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) != OP_FSET && $past(op_i) != OP_FCLR)
    |-> (status_o[FL_I] == $past(status_i[FL_I]) && status_o[FL_T] == $past(status_i[FL_T])));

  // R13: S tracks N xor V for every op that updates N and V
  a_r13_sign_rule: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) <= OP_ASR)
    |-> (status_o[FL_S] == (status_o[FL_N] ^ status_o[FL_V])));

  // R14: undefined codes do nothing
  a_r14_undef_idle: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) > OP_FCLR)
    |-> (!wr_o && status_o == $past(status_i) && result_o == $past(a_i)));
endmodule

bind alu8_status alu8_status_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i), .status_i(status_i),
  .result_o(result_o), .status_o(status_o), .wr_o(wr_o)
);

// File: tb/alu8_status_bench.sv
module alu8_status_bench;
  import alu8_status_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] op  = 5'd0;
  logic [7:0] a   = 8'h5A;
  logic [7:0] b   = 8'hC3;
  logic [7:0] st  = 8'hFF;
  logic [7:0] result_o, status_o;
  logic       wr_o;

  always #4 clk = ~clk;

  alu8_status u_alu8_status (
    .clk(clk), .rst(rst), .op_i(op), .a_i(a), .b_i(b), .status_i(st),
    .result_o(result_o), .status_o(status_o), .wr_o(wr_o)
  );

  int n_chk  = 0;
  int n_fail = 0;

  logic       pend = 1'b0;
  int         p_op;
  logic       e_wr;
  logic [7:0] e_res, e_st;

  function automatic int sx(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic string tag_of(int o);
    case (o)
      0, 1:           return "R2";
      2, 3:           return "R3";
      4, 5:           return "R4";
      6, 7, 8, 13:    return "R5";
      9:              return "R6";
      10:             return "R7";
      11, 12:         return "R8";
      14, 15, 18:     return "R9";
      16, 17:         return "R10";
      19:             return "R11";
      20, 21:         return "R12";
      default:        return "R14";
    endcase
  endfunction

  task automatic model(input int o, input int x, input int y, input logic [7:0] s,
                       output logic w, output logic [7:0] r, output logic [7:0] so);
    int full, sv, ci, xx, yy;
    logic upd, stk;
    logic [7:0] rr;
    so = s; rr = 8'(x); w = 1'b0; upd = 1'b0; stk = 1'b0;
    case (o)
      0, 1: begin
        ci = (o == 1) ? int'(s[FL_C]) : 0;
        full = x + y + ci; rr = 8'(full);
        so[FL_C] = full > 255;
        so[FL_H] = ((x % 16) + (y % 16) + ci) > 15;
        sv = sx(x) + sx(y) + ci;
        so[FL_V] = (sv > 127) || (sv < -128);
        upd = 1'b1; w = 1'b1;
      end
      2, 3, 4, 5, 10: begin
        xx = (o == 10) ? 0 : x;
        yy = (o == 10) ? x : y;
        ci = (o == 3 || o == 5) ? int'(s[FL_C]) : 0;
        full = xx - yy - ci; rr = 8'(full);
        so[FL_C] = full < 0;
        so[FL_H] = ((xx % 16) - (yy % 16) - ci) < 0;
        sv = sx(xx) - sx(yy) - ci;
        so[FL_V] = (sv > 127) || (sv < -128);
        stk = (o == 3 || o == 5);
        upd = 1'b1; w = !(o == 4 || o == 5);
      end
      6, 7, 8, 13: begin
        rr = (o == 6) ? 8'(x & y) : (o == 7) ? 8'(x | y) : (o == 8) ? 8'(x ^ y) : 8'(x);
        so[FL_V] = 1'b0; upd = 1'b1; w = 1'b1;
      end
      9: begin
        rr = 8'(255 - x); so[FL_C] = 1'b1; so[FL_V] = 1'b0; upd = 1'b1; w = 1'b1;
      end
      11, 12: begin
        rr = (o == 11) ? 8'(x + 1) : 8'(x - 1);
        so[FL_V] = (o == 11) ? (x == 127) : (x == 128);
        upd = 1'b1; w = 1'b1;
      end
      14, 15, 16, 17, 18: begin
        case (o)
          14: begin rr = 8'(x * 2);                      so[FL_C] = x >= 128; end
          16: begin rr = 8'(x * 2 + int'(s[FL_C]));      so[FL_C] = x >= 128; end
          15: begin rr = 8'(x / 2);                      so[FL_C] = x % 2 == 1; end
          17: begin rr = 8'(x / 2 + 128 * int'(s[FL_C])); so[FL_C] = x % 2 == 1; end
          default: begin rr = 8'(x / 2 + (x & 128));     so[FL_C] = x % 2 == 1; end
        endcase
        so[FL_V] = rr[7] ^ so[FL_C];
        upd = 1'b1; w = 1'b1;
      end
      19: begin rr = 8'((x % 16) * 16 + x / 16); w = 1'b1; end
      20: so[y % 8] = 1'b1;
      21: so[y % 8] = 1'b0;
      default: ;
    endcase
    if (upd) begin
      so[FL_N] = rr[7];
      so[FL_Z] = (rr == 8'h00) && (!stk || s[FL_Z]);
      so[FL_S] = so[FL_N] ^ so[FL_V];
    end
    r = rr;
  endtask

  task automatic check_prev();
    string tg;
    n_chk++;
    if (result_o !== e_res || status_o !== e_st || wr_o !== e_wr) begin
      n_fail++;
      if (result_o === e_res && wr_o === e_wr && ((status_o ^ e_st) & 8'b0010_1111) == 8'h00)
        tg = "R13";  // only S, I or T differ
      else
        tg = tag_of(p_op);
      $display("FAIL %s op=%0d: actual res=%h st=%h wr=%b, expected res=%h st=%h wr=%b",
               tg, p_op, result_o, status_o, wr_o, e_res, e_st, e_wr);
    end
  endtask

  // pipelined: each negedge checks the previous vector and drives the next
  task automatic step(input int o, input int x, input int y, input logic [7:0] s);
    @(negedge clk);
    if (pend) check_prev();
    model(o, x, y, s, e_wr, e_res, e_st);
    p_op = o;
    op = 5'(o); a = 8'(x); b = 8'(y); st = s;
    pend = 1'b1;
  endtask

  function automatic logic [7:0] mk_st(int x, int bi, int k, int cz);
    logic [7:0] v;
    v = 8'(x * 37 + bi * 11 + k * 83);
    v[1:0] = 2'(cz);
    return v;
  endfunction

  int bset[16] = '{0, 1, 2, 7, 8, 9, 15, 16, 60, 126, 127, 128, 129, 165, 240, 255};

  task automatic run_all();
    // R1: reset state
    repeat (3) @(negedge clk);
    n_chk++;
    if (result_o !== 8'h00 || status_o !== 8'h00 || wr_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: actual res=%h st=%h wr=%b, expected res=00 st=00 wr=0",
               result_o, status_o, wr_o);
    end
    rst = 1'b0;
    // R2 R3 R4: carry chain ops, all a, boundary b, all C/Z combinations
    for (int o = 0; o <= 5; o++)
      for (int x = 0; x < 256; x++)
        for (int bi = 0; bi < 16; bi++)
          for (int cz = 0; cz < 4; cz++)
            step(o, x, bset[bi], mk_st(x, bi, o, cz));
    // R5: AND, OR, XOR
    for (int o = 6; o <= 8; o++)
      for (int x = 0; x < 256; x++)
        for (int bi = 0; bi < 16; bi++)
          step(o, x, bset[bi], mk_st(x, bi, o, (x + bi) % 4));
    // R5 R6 R7 R8 R9 R10 R11: single-operand ops, all a, both carries
    for (int o = 9; o <= 19; o++)
      for (int x = 0; x < 256; x++)
        for (int cz = 0; cz < 4; cz++)
          step(o, x, 255 - x, mk_st(x, cz, o, cz));
    // R12: flag set/clear over every index and every incoming status byte
    for (int o = 20; o <= 21; o++)
      for (int idx = 0; idx < 8; idx++)
        for (int s = 0; s < 256; s++)
          step(o, s ^ 8'h3C, idx + 8 * (s % 32), 8'(s));
    // R14: undefined codes
    for (int o = 22; o < 32; o++)
      for (int k = 0; k < 16; k++)
        step(o, k * 17, k * 5, mk_st(k, o, k, k % 4));
    @(negedge clk);
    if (pend) check_prev();
    pend = 1'b0;
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog: actual run still busy, expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule